// File: doc/BRIEF.md
# Per-Branch Pattern-History Branch Predictor

This block predicts conditional branch direction from each branch's own recent behaviour. A branch is mapped to one of a fixed set of slots. Each slot keeps a short shift register of that branch's last outcomes and a private bank of two-bit saturating counters. The history value picks one counter in the bank, and the top bit of that counter is the prediction. Because each recent-outcome pattern trains its own counter, the predictor learns repeating sequences such as alternation or short periodic loops. A plain bias counter can only learn which way a branch usually goes.

The fetch side presents a program counter on the lookup port and gets a combinational taken/not-taken answer. When the branch resolves, the back end presents the same program counter and the actual outcome on the update port for one cycle. The slot's counter, selected by the history as it stood before this outcome, is trained, and then the outcome is shifted into the history. Slots carry no tags, so branches whose low address bits match share state.

Top module: `pattern_predictor`

## Requirements
- R1: The slot is the program counter bits [PC_LSB+SLOT_W-1:PC_LSB] (bits [5:2] by default), with no tag. Two addresses with equal slot bits share all state. An update to one slot leaves every other slot's prediction unchanged.
- R2: After reset every history is 0000 and every counter holds 1, so every lookup predicts not taken (`lk_taken` = 0).
- R3: `lk_taken` is 1 when the counter chosen by the slot's current 4-bit history holds 2 or 3, and 0 when it holds 0 or 1.
- R4: An update with taken = 1 increments the chosen counter and stops at 3. An update with taken = 0 decrements it and stops at 0.
- R5: An update shifts the outcome into bit 0 of the slot history, moves the older bits up one place, and drops bit 3.
- R6: The counter trained by an update is the one chosen by the history before that update's shift. Lookups during the update cycle still show the old state. The new state is visible from the next cycle on.
- R7: A strictly alternating outcome stream (0,1,0,1,...) on one branch gives no mispredictions once 4 + 2*2 outcomes have been seen from reset.
- R8: The period-five stream 0,0,1,0,1 repeated on one branch gives no mispredictions once 4 + 2*5 outcomes have been seen from reset.
- R9: While `up_valid` is 0, the `up_pc` and `up_taken` inputs change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Prediction for `lk_pc`: 1 means taken |
| up_valid | input | 1 | Update strobe for one resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
Counter saturation is the hardest case to reach from the ports. A specific history value has to recur enough times to drive its counter to the limit, and only then does the following outcome reveal whether the count wrapped. The directed vector table reaches this by repeating taken outcomes until the history reads 1111 and its counter has reached its upper limit. It then resolves not taken and checks that the prediction made just before that update was still taken. The periodic-pattern runs then check learning across many distinct history values. They count mispredictions only after the stated warm-up.

// File: rtl/bp_pkg.sv
// Shared widths and the counter step rule for the pattern-history predictor.
// Assumes a 2-bit counter and a 4-bit history per slot.
package bp_pkg;
    localparam int HIST_W = 4;
    localparam int CTR_W  = 2;
    typedef logic [CTR_W-1:0] ctr_t;
    localparam ctr_t CTR_RESET = ctr_t'(1);
    localparam ctr_t CTR_MAX   = ctr_t'((1 << CTR_W) - 1);

    // Saturating step: up on taken, down on not taken.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        if (taken) return (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
        else       return (cur == '0)      ? cur : cur - ctr_t'(1);
    endfunction
endpackage

// File: rtl/bp_slot_index.sv
// Maps a program counter to a slot number by taking low instruction-address bits.
// Assumes PC_LSB >= 1 (byte-offset bits below the instruction granule are dropped).
module bp_slot_index #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int SLOT_W = 4
) (
    input  logic [PC_W-1:0]   pc,
    output logic [SLOT_W-1:0] slot
);
    logic unused_pc_bits;

    // Select the slot field; the remaining address bits play no part.
    assign slot = pc[PC_LSB +: SLOT_W];
    assign unused_pc_bits = ^{pc[PC_W-1:PC_LSB+SLOT_W], pc[PC_LSB-1:0]};
endmodule

// File: rtl/bp_hist_table.sv
// Holds one outcome-history shift register per slot, with two read ports
// (lookup, update) and one shift-in write on the update slot.
// Assumes the write slot equals the update read slot.
module bp_hist_table #(
    parameter int SLOT_W = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_a_slot,
    output logic [HIST_W-1:0] rd_a_hist,
    input  logic [SLOT_W-1:0] rd_b_slot,
    output logic [HIST_W-1:0] rd_b_hist,
    input  logic              wr_en,
    input  logic              wr_bit
);
    localparam int SLOTS = 1 << SLOT_W;
    logic [SLOTS*HIST_W-1:0] hist_flat;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [HIST_W-1:0] hist_q;
        // Shift the resolved outcome into this slot's history on a matching update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hist_q <= '0;
            else if (wr_en && rd_b_slot == SLOT_W'(s))
                hist_q <= {hist_q[HIST_W-2:0], wr_bit};
        end
        assign hist_flat[s*HIST_W +: HIST_W] = hist_q;
    end

    // Combinational reads for the lookup and update ports.
    assign rd_a_hist = hist_flat[rd_a_slot*HIST_W +: HIST_W];
    assign rd_b_hist = hist_flat[rd_b_slot*HIST_W +: HIST_W];
endmodule

// File: rtl/bp_ctr_table.sv
// Holds every slot's bank of saturating counters as one flat array addressed
// by {slot, history}; two read ports and one training write.
// Assumes the write address equals the update read address.
module bp_ctr_table #(
    parameter int SEL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      rd_a_sel,
    output bp_pkg::ctr_t          rd_a_val,
    input  logic [SEL_W-1:0]      rd_b_sel,
    output bp_pkg::ctr_t          rd_b_val,
    input  logic                  wr_en,
    input  logic                  wr_taken
);
    localparam int N  = 1 << SEL_W;
    localparam int CW = bp_pkg::CTR_W;
    logic [N*CW-1:0] ctr_flat;

    for (genvar e = 0; e < N; e++) begin : g_ctr
        bp_pkg::ctr_t ctr_q;
        // Train this counter when the update port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctr_q <= bp_pkg::CTR_RESET;
            else if (wr_en && rd_b_sel == SEL_W'(e))
                ctr_q <= bp_pkg::ctr_step(ctr_q, wr_taken);
        end
        assign ctr_flat[e*CW +: CW] = ctr_q;
    end

    // Combinational reads for the lookup and update ports.
    assign rd_a_val = ctr_flat[rd_a_sel*CW +: CW];
    assign rd_b_val = ctr_flat[rd_b_sel*CW +: CW];
endmodule

// File: rtl/pattern_predictor.sv
// Two-level per-branch predictor: a slot's own history picks one of its own
// counters. Lookup is combinational; updates land at the clock edge.
// Assumes at most one update per cycle and untagged slots.
module pattern_predictor #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int SLOT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int HIST_W = bp_pkg::HIST_W;
    localparam int SEL_W  = SLOT_W + HIST_W;

    logic [SLOT_W-1:0] lk_slot, up_slot;
    logic [HIST_W-1:0] lk_hist, upd_hist;
    bp_pkg::ctr_t      lk_ctr, upd_ctr;

    bp_slot_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .SLOT_W(SLOT_W)) u_lk_idx (
        .pc(lk_pc), .slot(lk_slot));
    bp_slot_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .SLOT_W(SLOT_W)) u_up_idx (
        .pc(up_pc), .slot(up_slot));

    bp_hist_table #(.SLOT_W(SLOT_W), .HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .rd_a_slot(lk_slot), .rd_a_hist(lk_hist),
        .rd_b_slot(up_slot), .rd_b_hist(upd_hist),
        .wr_en(up_valid), .wr_bit(up_taken));

    bp_ctr_table #(.SEL_W(SEL_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel({lk_slot, lk_hist}), .rd_a_val(lk_ctr),
        .rd_b_sel({up_slot, upd_hist}), .rd_b_val(upd_ctr),
        .wr_en(up_valid), .wr_taken(up_taken));

    // Prediction is the upper half of the counter range.
    assign lk_taken = lk_ctr[bp_pkg::CTR_W-1];
endmodule

// File: rtl/bp_pred_chk.sv
// Property checker for pattern_predictor, attached by bind below.
module bp_pred_chk #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int SLOT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken,
    input logic [3:0]      up_hist,
    input logic [1:0]      up_ctr
);
    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_taken);

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid) && up_pc == $past(up_pc))
        |-> up_hist == {$past(up_hist[2:0]), $past(up_taken)});

    // R4
    ctr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid) && $past(up_taken)
         && up_pc == $past(up_pc) && up_hist == $past(up_hist))
        |-> (up_ctr >= $past(up_ctr)) && (up_ctr != 2'd0));

    // R4
    ctr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid) && !$past(up_taken)
         && up_pc == $past(up_pc) && up_hist == $past(up_hist))
        |-> (up_ctr <= $past(up_ctr)) && (up_ctr != 2'd3));

    // R3
    port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_pc == up_pc) |-> lk_taken == up_ctr[1]);

    // R1, R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(lk_pc)
         && (!$past(up_valid)
             || $past(up_pc[PC_LSB +: SLOT_W]) != lk_pc[PC_LSB +: SLOT_W]))
        |-> $stable(lk_taken));
endmodule

bind pattern_predictor bp_pred_chk #(.PC_W(PC_W), .PC_LSB(PC_LSB), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_hist(upd_hist), .up_ctr(upd_ctr));

// File: tb/pattern_predictor_bench.sv
`timescale 1ns/1ps
module pattern_predictor_bench;
    localparam int PC_W = 32;
    localparam int NVEC = 13;
    // Each vector: {outcome, expected prediction before that update}, slot 0.
    localparam logic [1:0] VEC [NVEC] = '{
        2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11,
        2'b01, 2'b00, 2'b10, 2'b10, 2'b11, 2'b11};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pattern_predictor u_pattern_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Look up pc, optionally compare, then apply one update; ends at a negedge.
    task automatic step(input logic [PC_W-1:0] pc, input logic t, output logic pred);
        lk_pc = pc; up_pc = pc; up_taken = t; up_valid = 1'b0;
        #1 pred = lk_taken;
        up_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic run_pattern(input logic [PC_W-1:0] pc, input logic [4:0] seq,
                               input int period, input int warm, input int len,
                               output int miss);
        logic p;
        miss = 0;
        for (int i = 0; i < len; i++) begin
            step(pc, seq[i % period], p);
            if (i >= warm && p != seq[i % period]) miss++;
        end
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic p;
        int miss;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset predicts not taken in several slots
        lk_pc = 32'h100; #1 check(lk_taken, 1'b0, "R2");
        lk_pc = 32'h124; #1 check(lk_taken, 1'b0, "R2");
        lk_pc = 32'h13C; #1 check(lk_taken, 1'b0, "R2");
        @(negedge clk);
        // R3 R4 R5: vector table on slot 0, incl. upper saturation
        for (int i = 0; i < NVEC; i++) begin
            step(32'h100, VEC[i][1], p);
            check(p, VEC[i][0], "R3/R4/R5 vector");
        end
        // R1: other slot untouched, alias shares state
        lk_pc = 32'h104; #1 check(lk_taken, 1'b0, "R1 other slot");
        lk_pc = 32'h140; #1 check(lk_taken, 1'b1, "R1 alias");
        // R9: strobe low, inputs wiggle, state unchanged
        lk_pc = 32'h100; up_pc = 32'h100; up_taken = 1'b0; up_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1 check(lk_taken, 1'b1, "R9");
        // R6: old state during update cycle, new state after
        up_valid = 1'b1;
        #1 check(lk_taken, 1'b1, "R6 same cycle");
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        #1 check(lk_taken, 1'b0, "R6 next cycle");
        @(negedge clk);
        // R7: alternating stream on slot 2
        run_pattern(32'h108, 5'b00010, 2, 8, 48, miss);
        total++;
        if (miss != 0) begin
            bad++;
            $display("FAIL R7: actual=%0d expected=0 mispredictions", miss);
        end
        // R8: 0,0,1,0,1 stream on slot 3
        run_pattern(32'h10C, 5'b10100, 5, 14, 64, miss);
        total++;
        if (miss != 0) begin
            bad++;
            $display("FAIL R8: actual=%0d expected=0 mispredictions", miss);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule